// File: doc/BRIEF.md
# Floating-Point Sign Manipulation Unit

This block performs the floating-point operations that touch only the sign of a value held in a 64-bit register: absolute value, negation and copy-sign, in either single or double precision. It does no rounding, raises no exception flags and never inspects a NaN. Every operand, including a signalling NaN, is handled as a plain bit pattern.

A single-precision value sits in the low 32 bits of the register. Single-precision absolute value and negation fill the upper 32 bits of their result with ones, so the result is NaN-boxed. Single-precision copy-sign does not NaN-box. It builds the whole 64-bit result from the two operands, and the bits above the single sign position come from operand k.

The result is registered. A valid strobe at the input gives a valid strobe at the output one cycle later. An unused operation code gives a zero result and raises an illegal-operation pulse.

Top module: `fpsign_unit`

## Requirements
- R1: Double absolute value (op code 3'b000, dbl_i=1): the result has bit 63 at 0 and bits 62:0 equal to bits 62:0 of operand j.
- R2: Double negation (op code 3'b001, dbl_i=1): the result equals operand j with bit 63 inverted.
- R3: Single absolute value (op code 3'b000, dbl_i=0): bits 31:0 of the result are bits 31:0 of operand j with bit 31 at 0, and bits 63:32 of the result are all ones.
- R4: Single negation (op code 3'b001, dbl_i=0): bits 31:0 of the result are bits 31:0 of operand j with bit 31 inverted, and bits 63:32 of the result are all ones.
- R5: Double copy-sign (op code 3'b010, dbl_i=1): result bit 63 comes from bit 63 of operand k, and result bits 62:0 come from operand j.
- R6: Single copy-sign (op code 3'b010, dbl_i=0): result bits 63:31 come from operand k and bits 30:0 come from operand j, with no NaN-boxing.
- R7: Quiet and signalling NaN operands get no special handling. Only the sign bit selected by R1 to R6 differs from the plain bit rule.
- R8: Op codes 3'b011 to 3'b111 give an all-zero result. illegal_o is high in the same cycle as that result's out_valid_o.
- R9: out_valid_o is high exactly one cycle after a cycle in which in_valid_i is high. The result of that input appears in that same cycle.
- R10: While rst_n is low at a clock edge, the edge clears out_valid_o, illegal_o and result_o to zero.
- R11: While in_valid_i is low, result_o keeps its last value and illegal_o stays low, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid_i | input | 1 | Operation request strobe |
| op_i | input | 3 | Operation code: 000 abs, 001 negate, 010 copy-sign, others illegal |
| dbl_i | input | 1 | Precision: 1 double, 0 single |
| opnd_j_i | input | 64 | Source operand j |
| opnd_k_i | input | 64 | Sign-source operand k (copy-sign) |
| out_valid_o | output | 1 | Result valid, one cycle after in_valid_i |
| result_o | output | 64 | Registered result |
| illegal_o | output | 1 | Unused op code seen, pulsed with out_valid_o |

## Verification
The bench builds the block with its default parameters: a 64-bit register width and a 32-bit single-precision width. These widths are fixed by the two floating-point formats. With them, the bench sweeps all eight op codes at both precisions over a grid of operands. The grid covers both sign states at bit 31 and bit 63, quiet and signalling NaNs in both formats, boxed and unboxed single values, and all-ones and all-zeros words. This reaches every boxing and sign-source corner and every illegal code. Added sequences check that the result holds and the illegal pulse drops while idle.

// File: rtl/fpsign_pkg.sv
// Package: shared operation codes and precision constants for the sign unit.
// Assumes: op codes are 3 bits wide; codes not listed here are illegal.
package fpsign_pkg;

    localparam int          FP_REG_W = 64;
    localparam int          FP_SP_W  = 32;

    localparam int          OP_W     = 3;
    localparam logic [2:0]  OP_ABS   = 3'b000;
    localparam logic [2:0]  OP_NEG   = 3'b001;
    localparam logic [2:0]  OP_CPY   = 3'b010;

    localparam int          LANE_SP  = 0;
    localparam int          LANE_DP  = 1;
    localparam int          N_LANES  = 2;

endpackage

// File: rtl/fpsign_lane.sv
// Module: fpsign_lane
// Computes abs, negate and copy-sign for one sign-bit position over the full
// register width. Assumes 0 < SIGN_POS < REG_W. No boxing is applied here.
module fpsign_lane #(
    parameter int REG_W    = 64,
    parameter int SIGN_POS = 63
) (
    input  logic [REG_W-1:0] opnd_j,
    input  logic [REG_W-1:0] opnd_k,
    output logic [REG_W-1:0] abs_v,
    output logic [REG_W-1:0] neg_v,
    output logic [REG_W-1:0] cpy_v
);

    // Sign-only transforms: clear, flip, or source the sign field from k.
    always_comb begin
        abs_v                 = opnd_j;
        abs_v[SIGN_POS]       = 1'b0;
        neg_v                 = opnd_j;
        neg_v[SIGN_POS]       = ~opnd_j[SIGN_POS];
        cpy_v                 = opnd_k;
        cpy_v[SIGN_POS-1:0]   = opnd_j[SIGN_POS-1:0];
    end

endmodule

// File: rtl/fpsign_select.sv
// Module: fpsign_select
// Picks the lane output named by op and precision, and flags unused codes.
// Assumes lane 0 is single precision and lane 1 is double precision.
module fpsign_select #(
    parameter int REG_W   = 64,
    parameter int N_LANES = 2
) (
    input  logic [2:0]       op,
    input  logic             dbl,
    input  logic [REG_W-1:0] abs_l [N_LANES],
    input  logic [REG_W-1:0] neg_l [N_LANES],
    input  logic [REG_W-1:0] cpy_l [N_LANES],
    output logic [REG_W-1:0] pick,
    output logic             need_box,
    output logic             illegal
);
    import fpsign_pkg::*;

    logic lane;
    assign lane = dbl;

    // Operation decode and lane selection; unused codes give zero.
    always_comb begin
        pick     = '0;
        need_box = 1'b0;
        illegal  = 1'b0;
        case (op)
            OP_ABS: begin
                pick     = abs_l[lane];
                need_box = ~dbl;
            end
            OP_NEG: begin
                pick     = neg_l[lane];
                need_box = ~dbl;
            end
            OP_CPY: pick = cpy_l[lane];
            default: illegal = 1'b1;
        endcase
    end

endmodule

// File: rtl/fpsign_box.sv
// Module: fpsign_box
// Forces the bits above the single-precision word to ones when boxing is
// requested. Assumes SP_W < REG_W.
module fpsign_box #(
    parameter int REG_W = 64,
    parameter int SP_W  = 32
) (
    input  logic [REG_W-1:0] raw,
    input  logic             box_en,
    output logic [REG_W-1:0] boxed
);
    localparam int HI_W = REG_W - SP_W;

    // Apply NaN-boxing to the upper field.
    always_comb begin
        boxed = raw;
        if (box_en) boxed[REG_W-1:SP_W] = {HI_W{1'b1}};
    end

endmodule

// File: rtl/fpsign_unit.sv
// Module: fpsign_unit (top)
// Sign-only floating-point operations with a registered result and a
// one-cycle valid. Assumes synchronous active-low reset. NaNs are treated as
// plain bits and no flags are produced.
module fpsign_unit #(
    parameter int REG_W = fpsign_pkg::FP_REG_W,
    parameter int SP_W  = fpsign_pkg::FP_SP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid_i,
    input  logic [2:0]       op_i,
    input  logic             dbl_i,
    input  logic [REG_W-1:0] opnd_j_i,
    input  logic [REG_W-1:0] opnd_k_i,
    output logic             out_valid_o,
    output logic [REG_W-1:0] result_o,
    output logic             illegal_o
);
    import fpsign_pkg::*;

    logic [REG_W-1:0] abs_l [N_LANES];
    logic [REG_W-1:0] neg_l [N_LANES];
    logic [REG_W-1:0] cpy_l [N_LANES];
    logic [REG_W-1:0] pick;
    logic [REG_W-1:0] next_res;
    logic             need_box;
    logic             illegal_c;

    // One lane per precision, differing only in sign position.
    for (genvar p = 0; p < N_LANES; p++) begin : g_lane
        localparam int SPOS = (p == LANE_SP) ? SP_W - 1 : REG_W - 1;
        fpsign_lane #(.REG_W(REG_W), .SIGN_POS(SPOS)) u_lane (
            .opnd_j (opnd_j_i),
            .opnd_k (opnd_k_i),
            .abs_v  (abs_l[p]),
            .neg_v  (neg_l[p]),
            .cpy_v  (cpy_l[p])
        );
    end

    fpsign_select #(.REG_W(REG_W), .N_LANES(N_LANES)) u_sel (
        .op       (op_i),
        .dbl      (dbl_i),
        .abs_l    (abs_l),
        .neg_l    (neg_l),
        .cpy_l    (cpy_l),
        .pick     (pick),
        .need_box (need_box),
        .illegal  (illegal_c)
    );

    fpsign_box #(.REG_W(REG_W), .SP_W(SP_W)) u_box (
        .raw    (pick),
        .box_en (need_box),
        .boxed  (next_res)
    );

    // Output register: valid follows input, result held while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_o <= 1'b0;
            result_o    <= '0;
            illegal_o   <= 1'b0;
        end else begin
            out_valid_o <= in_valid_i;
            illegal_o   <= in_valid_i & illegal_c;
            if (in_valid_i) result_o <= next_res;
        end
    end

endmodule

// File: rtl/fpsign_unit_chk.sv
// Module: fpsign_unit_chk
// Checker bound to fpsign_unit. It relates the registered outputs to the
// inputs of the previous cycle.
module fpsign_unit_chk #(
    parameter int REG_W = 64,
    parameter int SP_W  = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid_i,
    input logic [2:0]       op_i,
    input logic             dbl_i,
    input logic [REG_W-1:0] opnd_j_i,
    input logic [REG_W-1:0] opnd_k_i,
    input logic             out_valid_o,
    input logic [REG_W-1:0] result_o,
    input logic             illegal_o
);
    import fpsign_pkg::*;

    // R9
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i |=> out_valid_o);
    // R9
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i |=> !out_valid_o);
    // R8
    illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (out_valid_o && result_o == '0));
    // R3
    sp_box_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && !dbl_i && (op_i == OP_ABS || op_i == OP_NEG))
        |=> (result_o[REG_W-1:SP_W] == '1));
    // R2
    dp_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && dbl_i && op_i == OP_NEG)
        |=> (result_o[REG_W-1] != $past(opnd_j_i[REG_W-1]) &&
             result_o[REG_W-2:0] == $past(opnd_j_i[REG_W-2:0])));
    // R5
    dp_cpy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && dbl_i && op_i == OP_CPY)
        |=> (result_o[REG_W-1] == $past(opnd_k_i[REG_W-1]) &&
             result_o[REG_W-2:0] == $past(opnd_j_i[REG_W-2:0])));
    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i |=> ($stable(result_o) && !illegal_o));

endmodule

bind fpsign_unit fpsign_unit_chk #(.REG_W(REG_W), .SP_W(SP_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid_i  (in_valid_i),
    .op_i        (op_i),
    .dbl_i       (dbl_i),
    .opnd_j_i    (opnd_j_i),
    .opnd_k_i    (opnd_k_i),
    .out_valid_o (out_valid_o),
    .result_o    (result_o),
    .illegal_o   (illegal_o)
);

// File: tb/fpsign_unit_tb.sv
module fpsign_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid_i;
    logic [2:0]  op_i;
    logic        dbl_i;
    logic [63:0] opnd_j_i;
    logic [63:0] opnd_k_i;
    logic        out_valid_o;
    logic [63:0] result_o;
    logic        illegal_o;

    int errs   = 0;
    int checks = 0;

    logic [63:0] jpat [8];
    logic [63:0] kpat [4];

    always #5 clk = ~clk;

    fpsign_unit u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid_i  (in_valid_i),
        .op_i        (op_i),
        .dbl_i       (dbl_i),
        .opnd_j_i    (opnd_j_i),
        .opnd_k_i    (opnd_k_i),
        .out_valid_o (out_valid_o),
        .result_o    (result_o),
        .illegal_o   (illegal_o)
    );

    function automatic logic [63:0] model(logic [2:0] op, logic dbl,
                                          logic [63:0] j, logic [63:0] k);
        case (op)
            3'd0: return dbl ? {1'b0, j[62:0]} : {32'hFFFF_FFFF, 1'b0, j[30:0]};
            3'd1: return dbl ? {~j[63], j[62:0]} : {32'hFFFF_FFFF, ~j[31], j[30:0]};
            3'd2: return dbl ? {k[63], j[62:0]} : {k[63:31], j[30:0]};
            default: return 64'd0;
        endcase
    endfunction

    function automatic string tag(logic [2:0] op, logic dbl);
        if (op > 3'd2) return "R8";
        case ({op[1:0], dbl})
            3'b001: return "R1";
            3'b011: return "R2";
            3'b000: return "R3";
            3'b010: return "R4";
            3'b101: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Drive one request at a negedge, check the registered output at the next.
    task automatic apply(logic [2:0] op, logic dbl, logic [63:0] j,
                         logic [63:0] k, string req);
        in_valid_i = 1'b1; op_i = op; dbl_i = dbl; opnd_j_i = j; opnd_k_i = k;
        @(negedge clk);
        chk(req, result_o, model(op, dbl, j, k));
        chk("R9", {63'd0, out_valid_o}, 64'd1);
        chk((op > 3'd2) ? "R8" : req, {63'd0, illegal_o}, {63'd0, op > 3'd2});
    endtask

    initial begin
        #2_000_000;
        errs++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        jpat[0] = 64'h0000_0000_0000_0000;
        jpat[1] = 64'h8000_0000_8000_0000;
        jpat[2] = 64'h3FF0_0000_0000_0000;
        jpat[3] = 64'h7FF8_0000_0000_0000;   // double quiet NaN
        jpat[4] = 64'hFFF0_0000_0000_0001;   // negative double signalling NaN
        jpat[5] = 64'hFFFF_FFFF_7F80_0001;   // boxed single signalling NaN
        jpat[6] = 64'h0123_4567_89AB_CDEF;
        jpat[7] = 64'hFFFF_FFFF_FFFF_FFFF;
        kpat[0] = 64'h0000_0000_0000_0000;
        kpat[1] = 64'hFFFF_FFFF_FFFF_FFFF;
        kpat[2] = 64'h8000_0000_0000_0000;
        kpat[3] = 64'h5A5A_5A5A_8000_0000;

        rst_n = 1'b0; in_valid_i = 1'b1; op_i = 3'd5; dbl_i = 1'b0;
        opnd_j_i = '1; opnd_k_i = '1;
        repeat (3) @(negedge clk);
        // R10: reset clears outputs even with a request present
        chk("R10", result_o, 64'd0);
        chk("R10", {62'd0, out_valid_o, illegal_o}, 64'd0);
        in_valid_i = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        for (int o = 0; o < 8; o++)
            for (int d = 0; d < 2; d++)
                for (int a = 0; a < 8; a++)
                    for (int b = 0; b < 4; b++)
                        apply(3'(o), d[0], jpat[a], kpat[b], tag(3'(o), d[0]));

        // R7: signalling NaNs pass as bits, only the sign changes
        apply(3'd1, 1'b1, 64'h7FF0_0000_0000_0001, 64'd0, "R7");
        chk("R7", result_o, 64'hFFF0_0000_0000_0001);
        apply(3'd0, 1'b0, 64'h0000_0000_FF80_0001, 64'd0, "R7");
        chk("R7", result_o, 64'hFFFF_FFFF_7F80_0001);

        // R11: hold after an illegal op, then after a valid result
        apply(3'd6, 1'b1, 64'h1234, 64'h5678, "R8");
        in_valid_i = 1'b0; op_i = 3'd1; opnd_j_i = 64'h1111;
        @(negedge clk);
        chk("R11", result_o, 64'd0);
        chk("R11", {62'd0, out_valid_o, illegal_o}, 64'd0);
        apply(3'd2, 1'b1, 64'h0000_0000_0000_00AA, 64'h8000_0000_0000_0000, "R5");
        in_valid_i = 1'b0; op_i = 3'd0; opnd_j_i = 64'hFFFF; opnd_k_i = 64'd0;
        for (int n = 0; n < 3; n++) begin
            @(negedge clk);
            chk("R11", result_o, 64'h8000_0000_0000_00AA);
            chk("R9", {63'd0, out_valid_o}, 64'd0);
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule